// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Bridge with Bit-Order Mapping

This block sits between a host processor that has separate address and data buses and a peripheral that shares one 32-bit bus for both address and data. When the host starts an access with its active-low transfer-start strobe and the address falls inside the peripheral's decoded window, the bridge runs a cycle of three phases. First it drives the address onto the shared bus for one clock. Next comes a data phase whose bus direction depends on the access type. The data phase lasts as long as the peripheral holds off its active-low acknowledge. The bridge then returns to idle and signals ready to the host for one clock.

The shared bus is modelled as separate input, output and output-enable ports. A second enable, the data-in enable, tells the host-side buffers to pass peripheral data onto the host data bus. A host-select input picks the host's bit numbering. With a big-endian host (bit 0 is the MSB), every address and data bit n on the host side maps to shared-bus bit W-1-n. With a little-endian host, the bits pass straight through. The window decode compares the most significant address bits after this mapping.

Top module: `mux_bus_bridge`

## Requirements
- R1: While reset is held and right after it, bus_cs, bus_oe, din_en and host_rdy are 0, and bus_out and host_rdata are all zero.
- R2: In idle, host_ts_n low with a decode hit starts a cycle. A hit means that the top DEC_BITS bits of the mapped address, ANDed with MASK, equal BASE ANDed with MASK (defaults DEC_BITS=4, BASE=4'hA, MASK=4'hF). On the next clock bus_cs=1, bus_oe=1, din_en=0 and bus_out equals the mapped address. A miss starts no cycle, and bus_cs stays 0.
- R3: The address phase lasts exactly one clock. bus_ack_n is ignored during it, and the data phase always follows.
- R4: In the data phase of a write (host_wr=1 at start), bus_oe=1, din_en=0 and bus_out equals the mapped live host_wdata.
- R5: In the data phase of a read (host_wr=0 at start), bus_oe=0, din_en=1 and bus_out is zero. bus_oe and din_en are never both 1.
- R6: The data phase holds for any number of clocks while bus_ack_n is sampled high.
- R7: bus_ack_n sampled low in the data phase ends the cycle. On the next clock bus_cs, bus_oe and din_en are 0, and host_rdy is 1 for exactly that one clock.
- R8: On a read, host_rdata takes the mapped bus_in value sampled on the acknowledge clock, and it keeps that value until the next read completes. Writes leave it unchanged.
- R9: host_sel=0 maps bit n to bit W-1-n for address, write data and read data, and host_sel=1 passes bits straight through. The mode for the whole cycle is the value of host_sel at the start.
- R10: host_ts_n is ignored outside idle. Whenever bus_oe is 0, bus_out is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 1 | Host bit numbering: 0 big-endian, 1 little-endian |
| host_ts_n | input | 1 | Transfer start, active low |
| host_wr | input | 1 | 1 for write, 0 for read |
| host_addr | input | W | Host address bus |
| host_wdata | input | W | Host write data |
| host_rdata | output | W | Read data returned to the host |
| host_rdy | output | 1 | One-clock cycle-complete indication |
| bus_cs | output | 1 | Peripheral chip select, active high |
| bus_out | output | W | Shared-bus value to drive |
| bus_oe | output | 1 | Shared-bus drive enable |
| bus_in | input | W | Shared-bus value from the peripheral |
| din_en | output | 1 | Data-in enable toward the host data bus |
| bus_ack_n | input | 1 | Peripheral transfer acknowledge, active low |

## Verification
The hardest conditions to reach are the ones where an input changes while a cycle is in flight. One is an acknowledge that is already low during the address phase. Another is a host-select flip in the middle of a cycle, and a third is a fresh start strobe during wait states. The stimulus holds acknowledge low from the start strobe onward. During the address and data phases it drives the opposite host-select value, a new address and a low start strobe. It then checks that the data phase still follows the address phase, that the bit mapping follows the mode latched at the start, and that no second cycle begins. The sweep covers every decode value of the upper address bits in both host modes, with wait counts from zero to several clocks.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_DATA = 2'd2
   } phase_t;
endpackage

// File: rtl/bit_order_map.sv
module bit_order_map #(
   parameter int W         = 32,
   parameter bit ALLOW_REV = 1'b1
) (
   input  logic         rev,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   generate
      if (ALLOW_REV) begin : g_rev
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign dout[i] = rev ? din[W-1-i] : din[i];
         end
      end else begin : g_pass
         logic unused_rev;
         assign unused_rev = rev;
         assign dout = din;
      end
   endgenerate
endmodule

// File: rtl/addr_window_decode.sv
module addr_window_decode #(
   parameter int                  W        = 32,
   parameter int                  DEC_BITS = 4,
   parameter logic [DEC_BITS-1:0] BASE     = '0,
   parameter logic [DEC_BITS-1:0] MASK     = '1
) (
   input  logic [W-1:0] addr,
   output logic         hit
);
   localparam logic [DEC_BITS-1:0] MATCH = BASE & MASK;

   logic [DEC_BITS-1:0] upper;
   assign upper = addr[W-1 -: DEC_BITS];
   assign hit   = ((upper & MASK) == MATCH);

   generate
      if (DEC_BITS < W) begin : g_low
         logic unused_low;
         assign unused_low = ^addr[W-DEC_BITS-1:0];
      end
   endgenerate
endmodule

// File: rtl/bridge_phase_ctl.sv
module bridge_phase_ctl
   import bridge_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ts_n,
   input  logic         hit,
   input  logic         ack_n,
   input  logic         wr_in,
   input  logic         rev_in,
   input  logic [W-1:0] addr_in,
   output phase_t       phase,
   output logic         wr_q,
   output logic         rev_q,
   output logic [W-1:0] addr_q,
   output logic         done
);
   phase_t phase_nx;
   logic   start;

   assign start = (phase == PH_IDLE) && !ts_n && hit;
   assign done  = (phase == PH_DATA) && !ack_n;

   always_comb begin
      phase_nx = phase;
      unique case (phase)
         PH_IDLE: if (start) phase_nx = PH_ADDR;
         PH_ADDR: phase_nx = PH_DATA;
         PH_DATA: if (done) phase_nx = PH_IDLE;
         default: phase_nx = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         wr_q   <= 1'b0;
         rev_q  <= 1'b0;
         addr_q <= '0;
      end else begin
         phase <= phase_nx;
         if (start) begin
            wr_q   <= wr_in;
            rev_q  <= rev_in;
            addr_q <= addr_in;
         end
      end
   end
endmodule

// File: rtl/mux_bus_bridge.sv
module mux_bus_bridge
   import bridge_pkg::*;
#(
   parameter int                  W          = 32,
   parameter int                  DEC_BITS   = 4,
   parameter logic [DEC_BITS-1:0] BASE       = 4'hA,
   parameter logic [DEC_BITS-1:0] MASK       = 4'hF,
   parameter bit                  SUPPORT_BE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         host_sel,
   input  logic         host_ts_n,
   input  logic         host_wr,
   input  logic [W-1:0] host_addr,
   input  logic [W-1:0] host_wdata,
   output logic [W-1:0] host_rdata,
   output logic         host_rdy,
   output logic         bus_cs,
   output logic [W-1:0] bus_out,
   output logic         bus_oe,
   input  logic [W-1:0] bus_in,
   output logic         din_en,
   input  logic         bus_ack_n
);
   generate
      if (W < 2) begin : g_bad_w
         $error("mux_bus_bridge: W must be at least 2");
      end
      if (DEC_BITS < 1 || DEC_BITS > W) begin : g_bad_dec
         $error("mux_bus_bridge: DEC_BITS must lie in 1..W");
      end
   endgenerate

   phase_t       phase;
   logic         rev_live, rev_q, wr_q, done, dec_hit;
   logic [W-1:0] log_addr, addr_q, wdata_map, rdata_map;
   logic [W-1:0] rdata_q;
   logic         rdy_q;

   assign rev_live = !host_sel;

   bit_order_map #(.W(W), .ALLOW_REV(SUPPORT_BE)) i_map_addr (
      .rev(rev_live), .din(host_addr), .dout(log_addr));

   bit_order_map #(.W(W), .ALLOW_REV(SUPPORT_BE)) i_map_wdata (
      .rev(rev_q), .din(host_wdata), .dout(wdata_map));

   bit_order_map #(.W(W), .ALLOW_REV(SUPPORT_BE)) i_map_rdata (
      .rev(rev_q), .din(bus_in), .dout(rdata_map));

   addr_window_decode #(.W(W), .DEC_BITS(DEC_BITS), .BASE(BASE), .MASK(MASK)) i_dec (
      .addr(log_addr), .hit(dec_hit));

   bridge_phase_ctl #(.W(W)) i_ctl (
      .clk(clk), .rst_n(rst_n), .ts_n(host_ts_n), .hit(dec_hit),
      .ack_n(bus_ack_n), .wr_in(host_wr), .rev_in(rev_live),
      .addr_in(log_addr), .phase(phase), .wr_q(wr_q), .rev_q(rev_q),
      .addr_q(addr_q), .done(done));

   always_comb begin
      bus_cs  = (phase != PH_IDLE);
      bus_oe  = (phase == PH_ADDR) || ((phase == PH_DATA) && wr_q);
      din_en  = (phase == PH_DATA) && !wr_q;
      bus_out = '0;
      if (phase == PH_ADDR)
         bus_out = addr_q;
      else if ((phase == PH_DATA) && wr_q)
         bus_out = wdata_map;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
         rdy_q   <= 1'b0;
      end else begin
         rdy_q <= done;
         if (done && !wr_q)
            rdata_q <= rdata_map;
      end
   end

   assign host_rdata = rdata_q;
   assign host_rdy   = rdy_q;
endmodule

// File: rtl/bridge_chk.sv
module bridge_chk #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         host_ts_n,
   input logic         bus_ack_n,
   input logic         bus_cs,
   input logic         bus_oe,
   input logic         din_en,
   input logic         host_rdy,
   input logic [W-1:0] bus_out,
   input logic [1:0]   phase,
   input logic         dec_hit
);
   // R5
   dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      din_en |-> !bus_oe);

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_oe |-> (bus_out == '0));

   // R2
   start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_cs && !host_ts_n && dec_hit) |=> (bus_cs && bus_oe && !din_en));

   // R3
   addr_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 2'd1) |=> (phase == 2'd2));

   // R6
   wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase == 2'd2) && bus_ack_n) |=> (phase == 2'd2));

   // R7
   ack_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase == 2'd2) && !bus_ack_n) |=> (!bus_cs && host_rdy));

   // R7
   rdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      host_rdy |=> !host_rdy);
endmodule

bind mux_bus_bridge bridge_chk #(.W(W)) i_bridge_chk (
   .clk(clk), .rst_n(rst_n), .host_ts_n(host_ts_n), .bus_ack_n(bus_ack_n),
   .bus_cs(bus_cs), .bus_oe(bus_oe), .din_en(din_en), .host_rdy(host_rdy),
   .bus_out(bus_out), .phase(phase), .dec_hit(dec_hit));

// File: tb/test_mux_bus_bridge.sv
module test_mux_bus_bridge;
   localparam int CLK_PERIOD = 10;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         host_sel = 1'b1, host_ts_n = 1'b1, host_wr = 1'b0;
   logic [W-1:0] host_addr = '0, host_wdata = '0, bus_in = '0;
   logic         bus_ack_n = 1'b1;
   logic [W-1:0] host_rdata, bus_out;
   logic         host_rdy, bus_cs, bus_oe, din_en;

   int checks = 0, failures = 0;
   logic [W-1:0] exp_rdata = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mux_bus_bridge i_mux_bus_bridge (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_ts_n(host_ts_n),
      .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .host_rdy(host_rdy), .bus_cs(bus_cs),
      .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in), .din_en(din_en),
      .bus_ack_n(bus_ack_n));

   function automatic logic [W-1:0] flip(input logic [W-1:0] v);
      logic [W-1:0] r;
      for (int i = 0; i < W; i++) r[i] = v[W-1-i];
      return r;
   endfunction

   function automatic logic [W-1:0] mapv(input logic sel, input logic [W-1:0] v);
      return sel ? v : flip(v);
   endfunction

   task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic chk_ctl(input string tag, input logic cs, input logic oe, input logic de, input logic rdy);
      chk({tag, " cs"}, {31'd0, bus_cs}, {31'd0, cs});
      chk({tag, " oe"}, {31'd0, bus_oe}, {31'd0, oe});
      chk({tag, " din_en"}, {31'd0, din_en}, {31'd0, de});
      chk({tag, " rdy"}, {31'd0, host_rdy}, {31'd0, rdy});
   endtask

   // One full access; log_addr is the little-endian-numbered address.
   task automatic access(input logic sel, input logic [W-1:0] log_addr, input logic wr,
                         input logic [W-1:0] wdata, input logic [W-1:0] rdval,
                         input int waits, input logic early_ack);
      @(negedge clk);
      host_sel   = sel;
      host_addr  = mapv(sel, log_addr);
      host_wr    = wr;
      host_wdata = wdata;
      host_ts_n  = 1'b0;
      bus_ack_n  = early_ack ? 1'b0 : 1'b1;
      @(negedge clk);
      // R2 address phase
      chk_ctl("R2 addr", 1'b1, 1'b1, 1'b0, 1'b0);
      chk("R2 addr bus_out", bus_out, log_addr);
      // disturb inputs: mode flip, new address, start held low (R9, R10)
      host_sel  = ~sel;
      host_addr = ~host_addr;
      host_wr   = ~wr;
      @(negedge clk);
      // R3 data phase always follows; R4/R5 direction; R9 latched mapping
      if (wr) begin
         chk_ctl("R4 write data", 1'b1, 1'b1, 1'b0, 1'b0);
         chk("R4 R9 write bus_out", bus_out, mapv(sel, wdata));
      end else begin
         chk_ctl("R5 read data", 1'b1, 1'b0, 1'b1, 1'b0);
         chk("R5 read bus_out", bus_out, '0);
      end
      for (int k = 0; k < waits; k++) begin
         @(negedge clk);
         chk_ctl("R6 wait", 1'b1, wr, !wr, 1'b0);
      end
      host_ts_n = 1'b1;
      bus_ack_n = 1'b0;
      bus_in    = rdval;
      @(negedge clk);
      chk_ctl("R7 end", 1'b0, 1'b0, 1'b0, 1'b1);
      chk("R10 idle bus_out", bus_out, '0);
      if (!wr) exp_rdata = mapv(sel, rdval);
      chk("R8 R9 host_rdata", host_rdata, exp_rdata);
      bus_ack_n = 1'b1;
      bus_in    = '0;
      host_addr = '0;
      host_sel  = 1'b1;
      @(negedge clk);
      chk_ctl("R7 rdy once", 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R8 rdata held", host_rdata, exp_rdata);
   endtask

   task automatic miss(input logic sel, input logic [W-1:0] log_addr);
      @(negedge clk);
      host_sel  = sel;
      host_addr = mapv(sel, log_addr);
      host_ts_n = 1'b0;
      @(negedge clk);
      host_ts_n = 1'b1;
      chk_ctl("R2 miss", 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R2 miss bus_out", bus_out, '0);
      @(negedge clk);
      chk_ctl("R2 miss later", 1'b0, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 3 + 1);
      // R1 during reset
      chk_ctl("R1 in reset", 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R1 bus_out", bus_out, '0);
      chk("R1 host_rdata", host_rdata, '0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_ctl("R1 after reset", 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R1 host_rdata after", host_rdata, '0);

      // decode sweep over all upper nibbles, both host modes
      for (int s = 0; s < 2; s++) begin
         for (int n = 0; n < 16; n++) begin
            logic [W-1:0] la;
            la = {n[3:0], 28'h0} | (32'h0123_4567 + 32'(n * 977));
            if (n == 4'hA)
               access(s[0], la, n[0], 32'h8000_0001 << n, 32'h0000_00F1 ^ 32'(n), n % 4, 1'b0);
            else
               miss(s[0], la);
         end
      end

      // walking-one bit mapping, reads and writes, both modes, varied waits
      for (int s = 0; s < 2; s++) begin
         for (int b = 0; b < W; b += 3) begin
            access(s[0], 32'hA000_0000 | (32'h1 << (b % 28)), 1'b0, '0,
                   32'h1 << b, b % 5, 1'b0);
            access(s[0], 32'hAF00_0000, 1'b1, 32'h1 << b, '0, b % 3, 1'b0);
         end
      end

      // R3: acknowledge already low in address phase
      access(1'b0, 32'hA5A5_0000, 1'b0, '0, 32'hC0DE_1234, 0, 1'b1);
      access(1'b1, 32'hA000_00FF, 1'b1, 32'h1357_9BDF, '0, 0, 1'b1);
      // long wait with read
      access(1'b0, 32'hABCD_EF01, 1'b0, '0, 32'hDEAD_BEEF, 40, 1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule